// File: doc/BRIEF.md
# Windowed High-BER Monitor

This block sits in a 64b/66b receive path after block alignment. Each cycle it may receive the two sync-header bits of the block that was just aligned, together with a strobe. It counts malformed headers inside a fixed window of clock cycles. When the count for the current window reaches a threshold, it declares a high bit error rate. With the default settings (16 errors within a 125 µs window) this is an error rate worse than one in ten thousand.

A declaration produces a short pulse on the indicator output rather than a held level. A declaration is also an entry into the bad-header state, and the block keeps a saturating count of these entries. A synchronous clear input resets that count. The window length is a parameter in clock cycles. The default of 19531 cycles corresponds to 125 µs at a 156.25 MHz recovered clock, and a bench can use a much shorter window. All ports are synchronous to the recovered receive clock.

Top module: `hber_monitor`

## Requirements
- R1: A header with `hdr_stb` high is valid when `hdr_sync` is 2'b01 or 2'b10. The values 2'b00 and 2'b11 count as errors. When `hdr_stb` is low, `hdr_sync` is ignored.
- R2: A high-BER declaration happens on the cycle whose invalid header brings the count for the current window to ERR_THRESH (default 16). A window holding ERR_THRESH-1 errors makes no declaration, whether those errors arrive back to back or spread out.
- R3: `hi_ber` rises on the cycle after the declaring header. It stays high for exactly PULSE_LEN cycles (2 or 3, default 3) and then returns low.
- R4: A window makes at most one declaration. Further invalid headers in the same window produce no further pulse or entry.
- R5: Windows are WIN_CYCLES cycles long and follow each other with no gap. The first window starts on the first clock after reset. The error count for a window is dropped at the end of that window, so errors never add up across a window boundary. An error on the last cycle of a window still counts toward that window.
- R6: `bad_entries` increases by one for each declaration, visible on the cycle after the declaring header.
- R7: `entry_clr` sets `bad_entries` to zero on the next cycle. If a declaration happens on the same cycle, the clear wins, but the pulse is still issued.
- R8: `bad_entries` saturates at 2^CNT_W-1 and does not wrap.
- R9: A synchronous reset clears the window timer, the error count, the pulse and `bad_entries`. `hi_ber` is low on the cycle after reset, even if a pulse was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_stb | input | 1 | A new sync header is present this cycle |
| hdr_sync | input | 2 | Sync-header bits of the block that was just aligned |
| entry_clr | input | 1 | Synchronous clear of the entry count |
| hi_ber | output | 1 | High-BER pulse, PULSE_LEN cycles long |
| bad_entries | output | CNT_W | Saturating count of entries into the bad-header state |

## Verification
The bench puts 18 consecutive errors across a window boundary. A design that fails to clear the count at the window end would fire there. The bench also places the threshold-reaching error on the last cycle of a window. A design that clears the count before counting that error would miss the declaration, and one that keeps the count would suppress or double-fire the next window. Headers coded as valid, and invalid codes with the strobe low, check that only real errors are counted. A window with well over the threshold checks that only one entry is recorded. A design that wraps the entry count, lets an increment win over a same-cycle clear, or holds the pulse through a reset would show the wrong `bad_entries` or `hi_ber` value in the directed tests.

// File: rtl/hber_pkg.sv
`timescale 1ns/1ps
package hber_pkg;

   // Sync-header codes that mark a correctly framed block
   localparam logic [1:0] SYNC_DATA = 2'b01;
   localparam logic [1:0] SYNC_CTRL = 2'b10;

   // R1: 00 and 11 are not legal sync headers
   function automatic logic sync_is_bad(input logic [1:0] s);
      return !((s == SYNC_DATA) || (s == SYNC_CTRL));
   endfunction

endpackage

// File: rtl/hber_win_timer.sv
`timescale 1ns/1ps
module hber_win_timer #(
   parameter int WIN_CYCLES = 19531
) (
   input  logic clk,
   input  logic rst,
   output logic win_end
);
   localparam int  WIN_W    = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam bit  IS_POW2  = ((WIN_CYCLES & (WIN_CYCLES - 1)) == 0);

   if (WIN_CYCLES < 2) begin : g_bad_win
      $error("hber_win_timer: WIN_CYCLES must be at least 2");
   end

   logic [WIN_W-1:0] tick;

   if (IS_POW2) begin : g_pow2
      // Natural wrap of the counter closes the window
      always_ff @(posedge clk) begin
         if (rst) tick <= '0;
         else     tick <= tick + 1'b1;
      end
      assign win_end = &tick;
   end else begin : g_cmp
      localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);
      always_ff @(posedge clk) begin
         if (rst)               tick <= '0;
         else if (tick == LAST) tick <= '0;
         else                   tick <= tick + 1'b1;
      end
      assign win_end = (tick == LAST);
   end

endmodule

// File: rtl/hber_err_accum.sv
`timescale 1ns/1ps
module hber_err_accum
   import hber_pkg::*;
#(
   parameter int ERR_THRESH = 16,
   localparam int ERR_W     = $clog2(ERR_THRESH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hdr_stb,
   input  logic [1:0]       hdr_sync,
   input  logic             win_end,
   output logic             declare,
   output logic [ERR_W-1:0] err_cnt
);
   localparam logic [ERR_W-1:0] FULL = ERR_W'(ERR_THRESH);
   localparam logic [ERR_W-1:0] LAST = ERR_W'(ERR_THRESH - 1);

   if (ERR_THRESH < 1) begin : g_bad_thresh
      $error("hber_err_accum: ERR_THRESH must be at least 1");
   end

   logic bad_hdr;
   assign bad_hdr = hdr_stb && sync_is_bad(hdr_sync);

   // The error that reaches the threshold declares, even on the window's last cycle
   assign declare = bad_hdr && (err_cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst)                            err_cnt <= '0;
      else if (win_end)                   err_cnt <= '0;
      else if (bad_hdr && err_cnt != FULL) err_cnt <= err_cnt + 1'b1;
   end

endmodule

// File: rtl/hber_pulse_gen.sv
`timescale 1ns/1ps
module hber_pulse_gen #(
   parameter int PULSE_LEN = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic pulse
);
   if (PULSE_LEN < 2 || PULSE_LEN > 3) begin : g_bad_len
      $error("hber_pulse_gen: PULSE_LEN must be 2 or 3");
   end

   logic [PULSE_LEN-1:0] stage;

   always_ff @(posedge clk) begin
      if (rst) stage <= '0;
      else     stage <= {stage[PULSE_LEN-2:0], fire};
   end

   assign pulse = |stage;

endmodule

// File: rtl/hber_sat_cnt.sv
`timescale 1ns/1ps
module hber_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   if (W < 1) begin : g_bad_w
      $error("hber_sat_cnt: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst || clr)               count <= '0;
      else if (inc && count != MAXV) count <= count + 1'b1;
   end

endmodule

// File: rtl/hber_monitor.sv
`timescale 1ns/1ps
module hber_monitor #(
   parameter int WIN_CYCLES = 19531,
   parameter int ERR_THRESH = 16,
   parameter int PULSE_LEN  = 3,
   parameter int CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hdr_stb,
   input  logic [1:0]       hdr_sync,
   input  logic             entry_clr,
   output logic             hi_ber,
   output logic [CNT_W-1:0] bad_entries
);
   localparam int ERR_W = $clog2(ERR_THRESH + 1);

   if (WIN_CYCLES < ERR_THRESH) begin : g_bad_ratio
      $error("hber_monitor: window shorter than the error threshold");
   end

   logic             win_end;
   logic             declare;
   logic [ERR_W-1:0] err_cnt;

   hber_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .win_end (win_end)
   );

   hber_err_accum #(.ERR_THRESH(ERR_THRESH)) u_accum (
      .clk      (clk),
      .rst      (rst),
      .hdr_stb  (hdr_stb),
      .hdr_sync (hdr_sync),
      .win_end  (win_end),
      .declare  (declare),
      .err_cnt  (err_cnt)
   );

   hber_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk   (clk),
      .rst   (rst),
      .fire  (declare),
      .pulse (hi_ber)
   );

   hber_sat_cnt #(.W(CNT_W)) u_entries (
      .clk   (clk),
      .rst   (rst),
      .clr   (entry_clr),
      .inc   (declare),
      .count (bad_entries)
   );

endmodule

// File: rtl/hber_monitor_chk.sv
`timescale 1ns/1ps
module hber_monitor_chk #(
   parameter int ERR_THRESH = 16,
   parameter int CNT_W      = 8,
   localparam int ERR_W     = $clog2(ERR_THRESH + 1)
) (
   input logic             clk,
   input logic             rst,
   input logic             hdr_stb,
   input logic [1:0]       hdr_sync,
   input logic             entry_clr,
   input logic             win_end,
   input logic             declare,
   input logic [ERR_W-1:0] err_cnt,
   input logic             hi_ber,
   input logic [CNT_W-1:0] bad_entries
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   AST_VALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (!win_end && (!hdr_stb || hdr_sync == 2'b01 || hdr_sync == 2'b10)) |=> err_cnt == $past(err_cnt)); // R1
   AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
      err_cnt <= ERR_W'(ERR_THRESH)); // R2
   AST_ONE_PER_WIN: assert property (@(posedge clk) disable iff (rst)
      declare |=> (err_cnt == ERR_W'(ERR_THRESH) || $past(win_end))); // R4
   AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
      declare |=> hi_ber); // R3
   AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
      $rose(hi_ber) |=> hi_ber); // R3
   AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (rst)
      win_end |=> err_cnt == '0); // R5
   AST_ENTRY_INC: assert property (@(posedge clk) disable iff (rst)
      (declare && !entry_clr && bad_entries != MAXV) |=> bad_entries == $past(bad_entries) + CNT_W'(1)); // R6
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
      entry_clr |=> bad_entries == '0); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (bad_entries == MAXV && !entry_clr) |=> bad_entries == MAXV); // R8

endmodule

bind hber_monitor hber_monitor_chk #(
   .ERR_THRESH (ERR_THRESH),
   .CNT_W      (CNT_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .hdr_stb     (hdr_stb),
   .hdr_sync    (hdr_sync),
   .entry_clr   (entry_clr),
   .win_end     (win_end),
   .declare     (declare),
   .err_cnt     (err_cnt),
   .hi_ber      (hi_ber),
   .bad_entries (bad_entries)
);

// File: tb/hber_monitor_bench.sv
`timescale 1ns/1ps
module hber_monitor_bench;
   localparam int WIN   = 64;
   localparam int THR   = 16;
   localparam int PLEN  = 3;
   localparam int CW    = 3;
   localparam int NONE  = 127;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          hdr_stb = 1'b0;
   logic [1:0]    hdr_sync = 2'b01;
   logic          entry_clr = 1'b0;
   logic          hi_ber;
   logic [CW-1:0] bad_entries;

   int n_cmp = 0;
   int n_bad = 0;
   int ph = 0;
   int hi_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hber_monitor #(.WIN_CYCLES(WIN), .ERR_THRESH(THR), .PULSE_LEN(PLEN), .CNT_W(CW)) u_hber_monitor (
      .clk (clk), .rst (rst), .hdr_stb (hdr_stb), .hdr_sync (hdr_sync),
      .entry_clr (entry_clr), .hi_ber (hi_ber), .bad_entries (bad_entries)
   );

   // One stimulus row fills exactly one window, starting at its first cycle
   typedef struct packed {
      logic       stb;
      logic [1:0] code;
      logic [5:0] nbad;
      logic [1:0] gap;
      logic [2:0] exp_pulse;
      logic [2:0] exp_cnt;
   } row_t;

   localparam int NROWS = 7;
   localparam row_t ROWS [NROWS] = '{
      '{1'b1, 2'b00, 6'd15, 2'd0, 3'd0, 3'd0},  // R2 one below threshold
      '{1'b1, 2'b11, 6'd16, 2'd0, 3'd3, 3'd1},  // R2 exactly at threshold
      '{1'b1, 2'b00, 6'd20, 2'd1, 3'd3, 3'd2},  // R4 above threshold, one entry
      '{1'b1, 2'b11, 6'd16, 2'd2, 3'd3, 3'd3},  // R2 spread errors
      '{1'b1, 2'b10, 6'd30, 2'd0, 3'd0, 3'd3},  // R1 valid code 10
      '{1'b0, 2'b00, 6'd30, 2'd0, 3'd0, 3'd3},  // R1 strobe low
      '{1'b1, 2'b01, 6'd30, 2'd0, 3'd0, 3'd3}   // R1 valid code 01
   };

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic s, input logic [1:0] c, input logic cl);
      hdr_stb = s; hdr_sync = c; entry_clr = cl;
      @(posedge clk); #1;
      ph++;
      if (hi_ber) hi_cnt++;
   endtask

   task automatic idle_to(input int idx);
      while ((ph % WIN) != idx) cyc(1'b1, 2'b10, 1'b0);
   endtask

   task automatic run_window(input logic s, input logic [1:0] c, input int nbad,
                             input int gap, input int clr_at);
      for (int i = 0; i < WIN; i++) begin
         if ((i % (gap + 1)) == 0 && (i / (gap + 1)) < nbad)
            cyc(s, c, i == clr_at);
         else
            cyc(1'b1, 2'b01, i == clr_at);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) cyc(1'b0, 2'b01, 1'b0);
      rst = 1'b0;
      ph = 0;
   endtask

   initial begin
      do_reset();
      check("R9 reset hi_ber", int'(hi_ber), 0);
      check("R9 reset entries", int'(bad_entries), 0);

      for (int r = 0; r < NROWS; r++) begin
         hi_cnt = 0;
         run_window(ROWS[r].stb, ROWS[r].code, int'(ROWS[r].nbad), int'(ROWS[r].gap), NONE);
         check($sformatf("R3 R2 R1 row %0d pulse cycles", r), hi_cnt, int'(ROWS[r].exp_pulse));
         check($sformatf("R6 R4 row %0d entries", r), int'(bad_entries), int'(ROWS[r].exp_cnt));
      end

      // R7 plain clear
      cyc(1'b1, 2'b01, 1'b1);
      check("R7 clear", int'(bad_entries), 0);

      // R5 errors across a boundary never accumulate
      idle_to(54);
      hi_cnt = 0;
      for (int i = 0; i < 18; i++) cyc(1'b1, 2'b00, 1'b0);
      idle_to(0);
      check("R5 straddle no pulse", hi_cnt, 0);
      check("R5 straddle entries", int'(bad_entries), 0);

      // R5 threshold reached on the last cycle, next window starts fresh
      idle_to(48);
      hi_cnt = 0;
      for (int i = 0; i < 16; i++) cyc(1'b1, 2'b11, 1'b0);
      check("R3 last-cycle pulse start", int'(hi_ber), 1);
      run_window(1'b1, 2'b00, 15, 0, NONE);
      check("R5 last-cycle pulse cycles", hi_cnt, PLEN);
      check("R6 last-cycle entries", int'(bad_entries), 1);

      // R8 saturation
      for (int k = 0; k < 8; k++) begin
         hi_cnt = 0;
         run_window(1'b1, 2'b11, 16, 0, NONE);
         check($sformatf("R8 window %0d entries", k), int'(bad_entries), (k + 2 > 7) ? 7 : k + 2);
         check($sformatf("R3 window %0d pulse", k), hi_cnt, PLEN);
      end

      // R7 clear on the declaring cycle wins, pulse still issued
      hi_cnt = 0;
      run_window(1'b1, 2'b00, 16, 0, 15);
      check("R7 clear with declare entries", int'(bad_entries), 0);
      check("R7 clear with declare pulse", hi_cnt, PLEN);

      // R9 reset in the middle of a pulse
      for (int i = 0; i < 16; i++) cyc(1'b1, 2'b00, 1'b0);
      check("R3 pulse before reset", int'(hi_ber), 1);
      check("R6 entry before reset", int'(bad_entries), 1);
      rst = 1'b1;
      cyc(1'b1, 2'b00, 1'b0);
      check("R9 mid-pulse reset hi_ber", int'(hi_ber), 0);
      check("R9 mid-pulse reset entries", int'(bad_entries), 0);
      rst = 1'b0;
      ph = 0;
      hi_cnt = 0;
      run_window(1'b1, 2'b00, 15, 0, NONE);
      check("R9 window restarts", hi_cnt, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule